// File: doc/BRIEF.md
# Four-Phase Read Handshake Pair

This block holds both ends of a read carried over a shared bus with no common timing: a requester that asks for a word, and a responder that fetches it from a small read-only memory. Three control lines join the two sides: a read request, an acknowledge and a data-ready flag. One set of data lines carries the address first and the read data afterwards. Each side sees the other's control lines only through a two-flop synchronizer. Because of this, every step waits for the step before it to be seen, and no step relies on a cycle count.

A read runs as two four-phase handshakes in a row, and both use the same acknowledge line. In the first, the requester puts the address on the bus and raises the request. The responder captures the address and acknowledges. Then both lines return low. In the second, the responder waits a set number of cycles, puts the word on the bus and raises data-ready. The requester captures the word and acknowledges. Then both lines return low. The requester then gives a one-cycle done pulse that carries the word. The user drives `start_i` with an address while `busy_o` is low, and collects the result when `done_o` pulses. The control lines and the bus are brought out so that the exchange can be observed.

Top module: `hs_read_top`

## Requirements
- R1: After reset, read_req_o, ack_o, data_rdy_o, done_o and busy_o are low, bus_drive_o is 2'b00, and bus_o reads zero whenever no side drives it.
- R2: A start_i sampled while busy_o is low makes the next cycle show read_req_o high, busy_o high, bus_drive_o = 2'b01 (bit 0 is the requester, bit 1 is the responder) and bus_o equal to the address zero-extended.
- R3: ack_o rises only while read_req_o or data_rdy_o is high.
- R4: read_req_o falls only while ack_o is high, and the requester stops driving the bus in the same cycle.
- R5: data_rdy_o rises no sooner than LAT cycles after the responder's acknowledge falls.
- R6: While data_rdy_o is high, only the responder drives the bus (bus_drive_o = 2'b10), and the word on the bus is the memory word at the captured address. Word i of the memory is (i*37 + 90) mod 2^DW.
- R7: data_rdy_o falls only while ack_o is high. The transaction completes with read_req_o, ack_o and data_rdy_o all low.
- R8: bus_drive_o is never 2'b11.
- R9: A start_i sampled while busy_o is high is ignored. The read in progress keeps its address, and no extra done pulse appears.
- R10: done_o is a one-cycle pulse. In that cycle rdata_o holds the word read, and busy_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a read (taken only when idle) |
| addr_i | input | AW | Address of the read |
| busy_o | output | 1 | Requester is in a transaction |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read word |
| read_req_o | output | 1 | Read request line |
| ack_o | output | 1 | Shared acknowledge line |
| data_rdy_o | output | 1 | Data-ready line |
| bus_o | output | DW | Resolved data bus |
| bus_drive_o | output | 2 | Bus owners: bit 0 requester, bit 1 responder |

## Verification
Two things can happen in the same cycle: a new start_i arriving, and a read still in progress that owns the bus. The bench provokes this by pulsing start_i with a different address while the requester is still driving the first address. A scoreboard then judges the result. The bus must still show the first address, and the only done pulse must carry the first address's word. The second event is a hand-over of the shared acknowledge line: the responder's acknowledge falls, and later the requester's acknowledge rises. The bench times the gap between the falling acknowledge and the rising data-ready flag, and it checks the bus owner and the bus word at that rising edge.

// File: rtl/hs_read_pkg.sv
package hs_read_pkg;
  typedef enum logic [2:0] {RQ_IDLE, RQ_ADDR, RQ_WAIT, RQ_ACK, RQ_FIN} rq_state_e;
  typedef enum logic [2:0] {RS_IDLE, RS_ACK, RS_DROP, RS_LAT, RS_DATA, RS_REL} rs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_read_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  input  logic          ack_line_i,
  input  logic          rdy_line_i,
  input  logic [DW-1:0] bus_i,
  output logic          req_o,
  output logic          ack_o,
  output logic          drive_o,
  output logic [DW-1:0] bus_o,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  rq_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rdata_q;
  logic          done_q;
  logic [1:0]    sync_s;
  logic          ack_s, rdy_s;

  hs_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ack_line_i, rdy_line_i}),
    .q_o   (sync_s)
  );
  assign ack_s = sync_s[1];
  assign rdy_s = sync_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= RQ_IDLE;
      addr_q  <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        RQ_IDLE: if (start_i) begin
          addr_q <= addr_i;
          st_q   <= RQ_ADDR;
        end
        RQ_ADDR: if (ack_s) st_q <= RQ_WAIT;
        RQ_WAIT: if (rdy_s) begin
          rdata_q <= bus_i;
          st_q    <= RQ_ACK;
        end
        RQ_ACK:  if (!rdy_s) st_q <= RQ_FIN;
        // own acknowledge must be seen low before a new read may start
        RQ_FIN:  if (!ack_s) begin
          done_q <= 1'b1;
          st_q   <= RQ_IDLE;
        end
        default: st_q <= RQ_IDLE;
      endcase
    end
  end

  assign req_o   = (st_q == RQ_ADDR);
  assign drive_o = (st_q == RQ_ADDR);
  assign bus_o   = DW'(addr_q);
  assign ack_o   = (st_q == RQ_ACK);
  assign busy_o  = (st_q != RQ_IDLE);
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_read_pkg::*;
#(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_line_i,
  input  logic          ack_line_i,
  input  logic [DW-1:0] bus_i,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          drive_o,
  output logic [DW-1:0] bus_o
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = (LAT > 1) ? $clog2(LAT) : 1;

  rs_state_e     st_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [1:0]    sync_s;
  logic          req_s, ack_s;
  logic [DW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = DW'(i * 37 + 90);
  end

  hs_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({req_line_i, ack_line_i}),
    .q_o   (sync_s)
  );
  assign req_s = sync_s[1];
  assign ack_s = sync_s[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= RS_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      unique case (st_q)
        RS_IDLE: if (req_s) begin
          addr_q <= bus_i[AW-1:0];
          st_q   <= RS_ACK;
        end
        RS_ACK:  if (!req_s) st_q <= RS_DROP;
        // wait for own acknowledge to clear the synchronizer
        RS_DROP: if (!ack_s) begin
          cnt_q <= '0;
          st_q  <= RS_LAT;
        end
        RS_LAT: begin
          if (cnt_q == CW'(LAT - 1)) st_q <= RS_DATA;
          else cnt_q <= cnt_q + 1'b1;
        end
        RS_DATA: if (ack_s)  st_q <= RS_REL;
        RS_REL:  if (!ack_s) st_q <= RS_IDLE;
        default: st_q <= RS_IDLE;
      endcase
    end
  end

  assign ack_o   = (st_q == RS_ACK);
  assign rdy_o   = (st_q == RS_DATA);
  assign drive_o = (st_q == RS_DATA);
  assign bus_o   = rom[addr_q];
endmodule

// File: rtl/hs_read_top.sv
module hs_read_top #(
  parameter int AW  = 4,
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          read_req_o,
  output logic          ack_o,
  output logic          data_rdy_o,
  output logic [DW-1:0] bus_o,
  output logic [1:0]    bus_drive_o
);
  logic          rq_req, rq_ack, rq_drv, rs_ack, rs_rdy, rs_drv;
  logic [DW-1:0] rq_bus, rs_bus, bus;
  logic          ack_line;

  assign ack_line = rq_ack | rs_ack;
  // resolved bus: owner's value, zero when released
  assign bus = rq_drv ? rq_bus : (rs_drv ? rs_bus : '0);

  hs_requester #(.AW(AW), .DW(DW)) u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .addr_i    (addr_i),
    .ack_line_i(ack_line),
    .rdy_line_i(rs_rdy),
    .bus_i     (bus),
    .req_o     (rq_req),
    .ack_o     (rq_ack),
    .drive_o   (rq_drv),
    .bus_o     (rq_bus),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .rdata_o   (rdata_o)
  );

  hs_responder #(.AW(AW), .DW(DW), .LAT(LAT)) u_rsp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_line_i(rq_req),
    .ack_line_i(ack_line),
    .bus_i     (bus),
    .ack_o     (rs_ack),
    .rdy_o     (rs_rdy),
    .drive_o   (rs_drv),
    .bus_o     (rs_bus)
  );

  assign read_req_o  = rq_req;
  assign ack_o       = ack_line;
  assign data_rdy_o  = rs_rdy;
  assign bus_o       = bus;
  assign bus_drive_o = {rs_drv, rq_drv};
endmodule

// File: rtl/hs_read_chk.sv
module hs_read_chk #(
  parameter int DW  = 8,
  parameter int LAT = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done_o,
  input logic          read_req_o,
  input logic          ack_o,
  input logic          data_rdy_o,
  input logic [DW-1:0] bus_o,
  input logic [1:0]    bus_drive_o
);
  localparam int CW = $clog2(LAT + 2) + 1;
  logic [CW-1:0] low_cnt_q;

  // cycles with the acknowledge line low, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt_q <= '0;
    else if (ack_o) low_cnt_q <= '0;
    else if (low_cnt_q != '1) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_ack_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> (read_req_o || data_rdy_o));
  assert_req_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(read_req_o) |-> (ack_o && !bus_drive_o[0]));
  assert_rdy_delay_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_rdy_o) |-> (low_cnt_q >= CW'(LAT)));
  assert_rdy_owner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_rdy_o |-> (bus_drive_o == 2'b10));
  assert_rdy_fall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(data_rdy_o) |-> ack_o);
  assert_one_owner_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_drive_o != 2'b11);
  assert_idle_bus_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_drive_o == 2'b00) |-> (bus_o == '0));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind hs_read_top hs_read_chk #(.DW(DW), .LAT(LAT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .done_o     (done_o),
  .read_req_o (read_req_o),
  .ack_o      (ack_o),
  .data_rdy_o (data_rdy_o),
  .bus_o      (bus_o),
  .bus_drive_o(bus_drive_o)
);

// File: tb/hs_read_top_tb.sv
module hs_read_top_tb;
  localparam int AW  = 4;
  localparam int DW  = 8;
  localparam int LAT = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          busy_o, done_o, read_req_o, ack_o, data_rdy_o;
  logic [DW-1:0] rdata_o, bus_o;
  logic [1:0]    bus_drive_o;

  int n_run = 0, n_fail = 0, n_done = 0;
  bit finished = 0;
  logic [DW-1:0] exp_q[$];

  always #2 clk = ~clk;

  hs_read_top #(.AW(AW), .DW(DW), .LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .read_req_o(read_req_o), .ack_o(ack_o), .data_rdy_o(data_rdy_o),
    .bus_o(bus_o), .bus_drive_o(bus_drive_o)
  );

  function automatic logic [DW-1:0] mem_word(input int a);
    return DW'(a * 37 + 90);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    addr_i  = a;
    start_i = 1'b1;
    exp_q.push_back(mem_word(int'(a)));
    @(negedge clk);
    start_i = 1'b0;
    chk(read_req_o && busy_o && bus_drive_o == 2'b01, "R2 request/owner",
        {read_req_o, busy_o, bus_drive_o}, 4'b1101);
    chk(bus_o == DW'(a), "R2 address on bus", bus_o, a);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor: scoreboard pop, protocol timing
  logic prev_ack = 0, prev_rdy = 0, prev_done = 0, prev_req = 0;
  int   cyc = 0, ack_fall = 0, overlap = 0;
  always @(negedge clk) begin
    if (rst_ni) begin
      cyc++;
      if (bus_drive_o == 2'b11) overlap++;
      if (prev_ack && !ack_o) ack_fall = cyc;
      if (!prev_rdy && data_rdy_o) begin
        chk(cyc - ack_fall >= LAT, "R5 data-ready delay", cyc - ack_fall, LAT);
        chk(bus_drive_o == 2'b10, "R6 responder owns bus", bus_drive_o, 2);
        if (exp_q.size() != 0)
          chk(bus_o == exp_q[0], "R6 bus word", bus_o, exp_q[0]);
      end
      if (prev_req && !read_req_o)
        chk(ack_o && !bus_drive_o[0], "R4 request drop", {ack_o, bus_drive_o[0]}, 2'b10);
      if (done_o) begin
        n_done++;
        chk(!prev_done && !busy_o, "R10 pulse/busy", {prev_done, busy_o}, 0);
        chk(!read_req_o && !ack_o && !data_rdy_o, "R7 lines low at end",
            {read_req_o, ack_o, data_rdy_o}, 0);
        if (exp_q.size() == 0) chk(0, "R9 unexpected done", rdata_o, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_q.pop_front();
          chk(rdata_o == e, "R10 read word", rdata_o, e);
        end
      end
    end
    prev_ack = ack_o; prev_rdy = data_rdy_o; prev_done = done_o; prev_req = read_req_o;
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({read_req_o, ack_o, data_rdy_o, done_o, busy_o} == 0, "R1 reset lines",
        {read_req_o, ack_o, data_rdy_o, done_o, busy_o}, 0);
    chk(bus_drive_o == 2'b00 && bus_o == '0, "R1 released bus", {bus_drive_o, bus_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    do_read(4'h0);  drain();
    do_read(4'hF);  drain();
    do_read(4'h5);  drain();
    do_read(4'hA);  drain();

    // R9: second start while the first still owns the bus
    do_read(4'h3);
    addr_i = 4'hC; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    @(negedge clk);
    chk(bus_o == DW'(4'h3), "R9 address kept", bus_o, 3);
    drain();
    repeat (40) @(negedge clk);
    chk(n_done == 5, "R9 done count", n_done, 5);

    // back-to-back reads
    do_read(4'h9);
    do_read(4'h6);
    drain();
    chk(n_done == 7, "R10 total done", n_done, 7);
    chk(overlap == 0, "R8 single owner", overlap, 0);
    chk(bus_drive_o == 2'b00 && bus_o == '0, "R1 idle bus", {bus_drive_o, bus_o}, 0);
    summary();
  end
endmodule